// File: doc/BRIEF.md
# Serial Link Transmit Frame Formatter

This block assembles the parallel frames that a serializer shifts onto a serial link. Once per frame period it registers one frame, made of a payload, a flag bit and a fixed control field, and raises a one-cycle strobe. When the data-enable input is high at a frame boundary, the frame carries the user word. When it is low, the frame is one of two fill patterns, chosen by a fill-select input. The link carries no user data during those frames. Holding fill-select high and dropping data-enable for a while sends the second fill pattern, which the far end can use as a periodic sync pulse.

The flag bit has two modes. In the first, it alternates on every data frame, so the receiver can check a strict alternation. In the second, it is taken from a user pin, to mark the first and second halves of a word sent in two frames. A width input selects a 20-bit or a 16-bit payload. The control field always holds one falling edge at a fixed place, which the receiver uses to find the frame boundary.

Top module: `link_frame_fmt`

## Requirements
- R1: When `data_en_i` is 1 in the cycle where a frame is taken, the frame is a data frame: payload = `data_i` (masked per R3) and control field = 4'b0100.
- R2: When `data_en_i` is 0 in that cycle, a fill frame is sent. `fill_sel_i`=0 gives fill pattern 0: control 4'b1100, payload all zero. `fill_sel_i`=1 gives fill pattern 1: control 4'b0101, payload all ones across the active width.
- R3: `wide_mode_i`=1 selects a 20-bit payload. `wide_mode_i`=0 selects 16 bits, and payload bits 19:16 are 0 in every frame.
- R4: Frame layout: payload in `frame_o[19:0]`, flag in `frame_o[20]`, control in `frame_o[24:21]`. Read from bit 24 down to bit 21, the control field has exactly one 1-to-0 step, always between bit 23 (1) and bit 22 (0).
- R5: With `flag_user_en_i`=0, the flag of successive data frames alternates, and the first data frame after reset carries 0.
- R6: With `flag_user_en_i`=0, the toggle state holds during fill frames, and each fill frame carries the held value as its flag.
- R7: With `flag_user_en_i`=1, a data frame's flag equals `flag_user_i`, a fill frame's flag is 0, and the toggle state is frozen.
- R8: `frame_valid_o` pulses for one clock every FRAME_DIV clocks, starting FRAME_DIV clocks after reset release. Inputs are sampled in the clock before the pulse, and `frame_o` changes only when the pulse is high.
- R9: In reset, `frame_o` is fill pattern 0 with flag 0 (25'h1800000) and `frame_valid_o` is 0.
- R10: Until the first data frame after reset, every fill frame is fill pattern 0, whatever `fill_sel_i` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_en_i | input | 1 | 1: send user data, 0: send fill |
| fill_sel_i | input | 1 | Fill pattern choice (0 or 1) |
| wide_mode_i | input | 1 | 1: 20-bit payload, 0: 16-bit |
| flag_user_en_i | input | 1 | 1: flag from `flag_user_i`, 0: self-toggling flag |
| flag_user_i | input | 1 | User frame marker for double-frame mode |
| data_i | input | 20 | User payload word |
| frame_o | output | 25 | Formatted frame |
| frame_valid_o | output | 1 | One-clock strobe per new frame |

## Verification
The hardest case to reach is the held toggle state when fill frames and user-flag mode are mixed in with data frames. A lost or extra toggle shows only on the next data frame sent in toggle mode. The stimulus mixes long runs of data, bursts of fill and switches into user mode and back. It then checks the flag of the first data frame after each switch. A second sequence, run right after reset, asks for fill pattern 1 before any data has been sent, to check that fill pattern 0 is forced.

// File: rtl/lfmt_pkg.sv
package lfmt_pkg;
  localparam int CTRL_W = 4;

  typedef enum logic [1:0] {
    KIND_DATA = 2'd0,
    KIND_FILL0 = 2'd1,
    KIND_FILL1 = 2'd2
  } frame_kind_e;

  // Control field, read MSB first: one falling step between bit 2 and bit 1.
  function automatic logic [CTRL_W-1:0] ctrl_code(frame_kind_e kind);
    case (kind)
      KIND_DATA:  ctrl_code = 4'b0100;
      KIND_FILL1: ctrl_code = 4'b0101;
      default:    ctrl_code = 4'b1100;
    endcase
  endfunction
endpackage

// File: rtl/link_frame_timer.sv
module link_frame_timer #(
  parameter int FRAME_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CNT_W = (FRAME_DIV > 1) ? $clog2(FRAME_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/link_flag_gen.sv
module link_flag_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic is_data_i,
  input  logic user_en_i,
  input  logic user_flag_i,
  output logic flag_o,
  output logic toggle_q_o
);
  logic toggle_q;
  logic advance;

  assign advance = tick_i && is_data_i && !user_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) toggle_q <= 1'b0;
    else if (advance) toggle_q <= ~toggle_q;
  end

  always_comb begin
    if (user_en_i) flag_o = is_data_i ? user_flag_i : 1'b0;
    else flag_o = toggle_q;
  end

  assign toggle_q_o = toggle_q;

  AST_TOGGLE_FLIPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    advance |=> (toggle_q != $past(toggle_q))); // R5
  AST_TOGGLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && (!is_data_i || user_en_i)) |=> $stable(toggle_q)); // R6
endmodule

// File: rtl/link_frame_build.sv
module link_frame_build
  import lfmt_pkg::*;
#(
  parameter int PAY_W = 20,
  parameter int NARROW_W = 16
) (
  input  frame_kind_e               kind_i,
  input  logic                      wide_i,
  input  logic [PAY_W-1:0]          data_i,
  input  logic                      flag_i,
  output logic [PAY_W+CTRL_W:0]     frame_o
);
  function automatic logic [PAY_W-1:0] width_mask(logic wide);
    logic [PAY_W-1:0] m;
    for (int i = 0; i < PAY_W; i++) m[i] = wide || (i < NARROW_W);
    return m;
  endfunction

  logic [PAY_W-1:0] raw_pay;

  always_comb begin
    case (kind_i)
      KIND_DATA:  raw_pay = data_i;
      KIND_FILL1: raw_pay = '1;
      default:    raw_pay = '0;
    endcase
  end

  assign frame_o = {ctrl_code(kind_i), flag_i, raw_pay & width_mask(wide_i)};
endmodule

// File: rtl/link_frame_fmt.sv
module link_frame_fmt
  import lfmt_pkg::*;
#(
  parameter int PAY_W = 20,
  parameter int NARROW_W = 16,
  parameter int FRAME_DIV = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      data_en_i,
  input  logic                      fill_sel_i,
  input  logic                      wide_mode_i,
  input  logic                      flag_user_en_i,
  input  logic                      flag_user_i,
  input  logic [PAY_W-1:0]          data_i,
  output logic [PAY_W+CTRL_W:0]     frame_o,
  output logic                      frame_valid_o
);
  localparam int FW = PAY_W + CTRL_W + 1;
  localparam logic [FW-1:0] RESET_FRAME = {ctrl_code(KIND_FILL0), 1'b0, {PAY_W{1'b0}}};

  logic          tick;
  logic          seen_data_q;
  logic          flag_bit;
  logic          toggle_q;
  frame_kind_e   kind;
  logic [FW-1:0] next_frame;

  link_frame_timer #(.FRAME_DIV(FRAME_DIV)) timer_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick));

  always_comb begin
    if (data_en_i) kind = KIND_DATA;
    else if (fill_sel_i && seen_data_q) kind = KIND_FILL1;
    else kind = KIND_FILL0;
  end

  link_flag_gen flag_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .is_data_i(data_en_i), .user_en_i(flag_user_en_i),
    .user_flag_i(flag_user_i), .flag_o(flag_bit), .toggle_q_o(toggle_q));

  link_frame_build #(.PAY_W(PAY_W), .NARROW_W(NARROW_W)) build_i (
    .kind_i(kind), .wide_i(wide_mode_i), .data_i(data_i),
    .flag_i(flag_bit), .frame_o(next_frame));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_o       <= RESET_FRAME;
      frame_valid_o <= 1'b0;
      seen_data_q   <= 1'b0;
    end else begin
      frame_valid_o <= tick;
      if (tick) begin
        frame_o <= next_frame;
        if (data_en_i) seen_data_q <= 1'b1;
      end
    end
  end

  AST_MASTER_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o[FW-2] && !frame_o[FW-3]); // R4
  AST_HELD_BETWEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_valid_o |-> $stable(frame_o)); // R8
  AST_SINGLE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (FRAME_DIV > 1 && frame_valid_o) |=> !frame_valid_o); // R8
  AST_NARROW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !wide_mode_i) |=> (frame_o[PAY_W-1:NARROW_W] == '0)); // R3
  AST_FILL0_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !data_en_i && !seen_data_q) |=>
      (frame_o[FW-1:PAY_W+1] == ctrl_code(KIND_FILL0))); // R10
  AST_USER_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && data_en_i && flag_user_en_i) |=> (frame_o[PAY_W] == $past(flag_user_i))); // R7
endmodule

// File: tb/link_frame_fmt_tb_top.sv
module link_frame_fmt_tb_top;
  localparam int DIV = 4;
  logic clk = 0, rst_n = 0;
  logic den = 0, fsel = 0, wide = 1, uen = 0, uflag = 0;
  logic [19:0] din = '0;
  logic [24:0] fout;
  logic fval;
  int n_checks = 0, n_fail = 0;

  always #4 clk = ~clk;

  link_frame_fmt #(.PAY_W(20), .NARROW_W(16), .FRAME_DIV(DIV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .data_en_i(den), .fill_sel_i(fsel),
    .wide_mode_i(wide), .flag_user_en_i(uen), .flag_user_i(uflag),
    .data_i(din), .frame_o(fout), .frame_valid_o(fval));

  // behavioural reference
  int m_phase = 0;
  bit m_seen = 0, m_tog = 0, m_val = 0;
  int m_ctrl = 12, m_flag = 0, m_pay = 0;
  string m_tag_pay = "R9", m_tag_flag = "R9", m_tag_ctrl = "R9";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_seen = 0; m_tog = 0; m_val = 0;
      m_ctrl = 12; m_flag = 0; m_pay = 0;
      m_tag_pay = "R9"; m_tag_flag = "R9"; m_tag_ctrl = "R9";
    end else begin
      m_val = (m_phase == DIV - 1);
      if (m_val) begin
        int lim;
        lim = wide ? (1 << 20) - 1 : (1 << 16) - 1;
        if (den) begin
          m_ctrl = 4; m_pay = int'(din) & lim; m_tag_ctrl = "R1";
          m_tag_pay = wide ? "R1" : "R3";
          if (uen) begin m_flag = uflag; m_tag_flag = "R7"; end
          else begin m_flag = m_tog; m_tog = !m_tog; m_tag_flag = "R5"; end
          m_seen = 1;
        end else begin
          if (fsel && m_seen) begin m_ctrl = 5; m_pay = lim; end
          else begin m_ctrl = 12; m_pay = 0; end
          m_tag_ctrl = (fsel && !m_seen) ? "R10" : "R2";
          m_tag_pay = m_tag_ctrl;
          m_flag = uen ? 0 : m_tog;
          m_tag_flag = uen ? "R7" : "R6";
        end
      end
      m_phase = (m_phase + 1) % DIV;
    end
  end

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  bit run_checks = 0;
  always @(negedge clk) if (run_checks) begin
    check("R8 valid", int'(fval), int'(m_val));
    check({m_tag_ctrl, " ctrl"}, int'(fout[24:21]), m_ctrl);
    check({m_tag_flag, " flag"}, int'(fout[20]), m_flag);
    check({m_tag_pay, " payload"}, int'(fout[19:0]), m_pay);
    // R4: exactly one falling step, at bits 23->22
    check("R4 master edge", int'(fout[23] && !fout[22] && !(fout[24] && !fout[23])
                                 && !(fout[22] && !fout[21])), 1);
  end

  task automatic frames(int n);
    repeat (n * DIV) @(negedge clk);
  endtask

  initial begin : watchdog
    #1600000;
    n_fail++; n_checks++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 reset frame", int'(fout), 32'h1800000);
    check("R9 reset valid", int'(fval), 0);
    rst_n = 1; run_checks = 1;
    // R10: fill pattern 1 requested before any data
    fsel = 1; frames(3);
    // R1/R5 data in wide mode
    den = 1;
    for (int i = 0; i < 6; i++) begin din = 20'hA5000 + 20'(i * 4097); frames(1); end
    // R6: fill bursts between data, R2 both patterns
    den = 0; fsel = 1; frames(2);
    fsel = 0; frames(2);
    den = 1; din = 20'hFFFFF; frames(3);
    // R3 narrow mode
    wide = 0; frames(2); den = 0; fsel = 1; frames(2); fsel = 0; frames(1);
    wide = 1;
    // R7 user marker mode, double-frame style
    uen = 1; den = 1;
    for (int i = 0; i < 6; i++) begin uflag = i[0]; din = 20'(i * 313); frames(1); end
    den = 0; frames(2);
    uen = 0; den = 1; frames(3);
    // periodic sync pulse pattern
    fsel = 1;
    for (int k = 0; k < 4; k++) begin den = 1; frames(5); den = 0; frames(2); end
    // mixed stimulus
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      den = ($urandom % 4) != 0; fsel = $urandom % 2; wide = ($urandom % 5) != 0;
      uen = ($urandom % 6) == 0; uflag = $urandom % 2; din = 20'($urandom);
    end
    // reset mid-run, then R10 again
    @(negedge clk); rst_n = 0; run_checks = 0; den = 0; fsel = 1;
    @(negedge clk);
    check("R9 reset frame again", int'(fout), 32'h1800000);
    rst_n = 1; run_checks = 1; frames(3);
    run_checks = 0;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule